// File: doc/BRIEF.md
# Bitstream header ratio detector

This block taps a 32-bit valid/ready stream that carries a configuration image. It watches the leading header words. From two fixed header positions it recovers two option flags: whether the image is encrypted and whether it is compressed. It then combines those flags with a port-width selection to form a 2-bit clock-to-data ratio code. The code is logarithmic: 0 means x1, 1 means x2, 2 means x4 and 3 means x8. A downstream configuration driver uses this code to set how many clock edges it spends on each data word.

A synchronous start pulse arms the block. The start pulse also samples the width selection. After the final header word is accepted, the block issues a one-cycle result strobe. It then holds the code and the flags and keeps accepting payload words without looking at them. If the stream ends before the header is complete, the block issues a one-cycle error strobe instead and reports no ratio.

The controller has four states. `IDLE` is the state after reset. `PARSE` counts and inspects header words. `READY` holds a valid result. `ABORT` holds an early-end error. The transitions are as follows:
- start_i from any state goes to `PARSE`.
- In `PARSE`, an accepted final header word goes to `READY`.
- In `PARSE`, an accepted word marked last before the final header word goes to `ABORT`.
- Nothing else leaves `READY` or `ABORT`. `IDLE` is left only on start.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, s_ready_o, res_valid_o, err_o, ratio_o, enc_o and cmp_o are all 0.
- R2: start_i clears the word count and both flags and latches cfg_wide_i. During the start cycle s_ready_o is 0, and a beat offered in that cycle is not counted.
- R3: Words are counted from 0. The image is encrypted when bits [3:2] of word 69 are not both zero. The same bits in any other word have no effect.
- R4: The image is compressed when bit 1 of word 229 is 0. Bit 1 of any other word has no effect.
- R5: With cfg_wide_i=0 (16-bit port), the code is 0 when neither flag is set, 1 when only encrypted, and 2 when compressed (with or without encryption).
- R6: With cfg_wide_i=1 (32-bit port), the code is 0 when neither flag is set, 2 when only encrypted, and 3 when compressed.
- R7: res_valid_o is high for exactly the one cycle after the edge that accepts word 229. From that cycle on, ratio_o, enc_o and cmp_o hold their values until the next start. Later payload words change none of them.
- R8: A beat with s_last_i=1 accepted as word 0..228 raises err_o for one cycle. ratio_o, enc_o and cmp_o are then 0, no result strobe appears, and s_ready_o stays 0 until the next start.
- R9: A beat with s_last_i=1 that is itself word 229 completes the header normally: the result strobe appears and err_o does not.
- R10: Only beats with s_valid_i and s_ready_o both high are counted. Idle cycles in the middle of the header do not shift word positions, and beats offered in IDLE or ABORT are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous start of a new header |
| cfg_wide_i | input | 1 | Port width: 1 = 32-bit, 0 = 16-bit; sampled on start |
| s_valid_i | input | 1 | Stream word valid |
| s_data_i | input | 32 | Stream word |
| s_last_i | input | 1 | Marks the final word of the stream |
| s_ready_o | output | 1 | Block accepts a word this cycle |
| res_valid_o | output | 1 | One-cycle strobe: header complete |
| err_o | output | 1 | One-cycle strobe: stream ended inside the header |
| ratio_o | output | 2 | Ratio code (0=x1, 1=x2, 2=x4, 3=x8) |
| enc_o | output | 1 | Encrypted flag |
| cmp_o | output | 1 | Compressed flag |

## Verification
Two functions can fall on the same edge: completing the header and detecting the end of the stream. This happens when the word marked last is exactly word 229. The bench sends such a stream and requires a result strobe with the correct code and no error strobe. It also sends a stream that ends on word 100, where only the error strobe may appear. A second collision is a start pulse together with a valid beat. The bench judges this case by giving the uncounted beat contents that would move the encryption word by one position if it were counted.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PARSE = 2'd1,
        ST_READY = 2'd2,
        ST_ABORT = 2'd3
    } hdr_state_t;

    localparam logic [1:0] RATIO_X1 = 2'd0;
    localparam logic [1:0] RATIO_X2 = 2'd1;
    localparam logic [1:0] RATIO_X4 = 2'd2;

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (adv_i) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
    parameter int CNT_W    = 8,
    parameter int ENC_W    = 2,
    parameter int ENC_WORD = 69,
    parameter int CMP_WORD = 229
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             beat_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [ENC_W-1:0] enc_field_i,
    input  logic             cmp_bit_i,
    output logic             enc_q_o,
    output logic             cmp_q_o
);

    localparam logic [CNT_W-1:0] ENC_IDX = CNT_W'(ENC_WORD);
    localparam logic [CNT_W-1:0] CMP_IDX = CNT_W'(CMP_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q_o <= 1'b0;
            cmp_q_o <= 1'b0;
        end else if (clr_i) begin
            enc_q_o <= 1'b0;
            cmp_q_o <= 1'b0;
        end else if (beat_i) begin
            if (count_i == ENC_IDX) begin
                enc_q_o <= |enc_field_i;
            end
            if (count_i == CMP_IDX) begin
                // the compression bit is active-low
                cmp_q_o <= ~cmp_bit_i;
            end
        end
    end

endmodule

// File: rtl/hdr_ratio_map.sv
module hdr_ratio_map
    import hdr_ratio_pkg::*;
(
    input  logic       wide_i,
    input  logic       enc_i,
    input  logic       cmp_i,
    output logic [1:0] ratio_o
);

    logic [1:0] base_code;

    always_comb begin
        unique case ({cmp_i, enc_i})
            2'b00:   base_code = RATIO_X1;
            2'b01:   base_code = RATIO_X2;
            default: base_code = RATIO_X4;
        endcase
        // a 32-bit port doubles every ratio above x1
        if (wide_i && (base_code != RATIO_X1)) begin
            ratio_o = base_code + 2'd1;
        end else begin
            ratio_o = base_code;
        end
    end

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
    import hdr_ratio_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ENC_WORD = 69,
    parameter int ENC_LSB  = 2,
    parameter int ENC_W    = 2,
    parameter int CMP_WORD = 229,
    parameter int CMP_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cfg_wide_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic              res_valid_o,
    output logic              err_o,
    output logic [1:0]        ratio_o,
    output logic              enc_o,
    output logic              cmp_o
);

    localparam int               CNT_W   = $clog2(CMP_WORD + 1);
    localparam logic [CNT_W-1:0] CMP_IDX = CNT_W'(CMP_WORD);

    hdr_state_t       state_q, state_d;
    logic [CNT_W-1:0] word_cnt;
    logic             beat;
    logic             parse_beat;
    logic             hdr_end;
    logic             enc_q, cmp_q;
    logic             wide_q;
    logic [1:0]       ratio_raw;
    logic             res_q, err_q;

    assign beat       = s_valid_i && s_ready_o;
    assign parse_beat = beat && (state_q == ST_PARSE);
    assign hdr_end    = (word_cnt == CMP_IDX);

    hdr_word_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_i),
        .adv_i   (parse_beat && !hdr_end),
        .count_o (word_cnt)
    );

    hdr_flag_capture #(
        .CNT_W    (CNT_W),
        .ENC_W    (ENC_W),
        .ENC_WORD (ENC_WORD),
        .CMP_WORD (CMP_WORD)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (start_i),
        .beat_i      (parse_beat),
        .count_i     (word_cnt),
        .enc_field_i (s_data_i[ENC_LSB +: ENC_W]),
        .cmp_bit_i   (s_data_i[CMP_BIT]),
        .enc_q_o     (enc_q),
        .cmp_q_o     (cmp_q)
    );

    hdr_ratio_map u_map (
        .wide_i  (wide_q),
        .enc_i   (enc_q),
        .cmp_i   (cmp_q),
        .ratio_o (ratio_raw)
    );

    // state register and width latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                wide_q <= cfg_wide_i;
            end
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_PARSE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_PARSE: begin
                    if (parse_beat && hdr_end) begin
                        state_d = ST_READY;
                    end else if (parse_beat && s_last_i) begin
                        state_d = ST_ABORT;
                    end
                end
                ST_READY: state_d = ST_READY;
                ST_ABORT: state_d = ST_ABORT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            res_q <= parse_beat && hdr_end;
            err_q <= parse_beat && !hdr_end && s_last_i;
        end
    end

    // level outputs
    always_comb begin
        s_ready_o   = ((state_q == ST_PARSE) || (state_q == ST_READY)) && !start_i;
        res_valid_o = res_q;
        err_o       = err_q;
        if (state_q == ST_READY) begin
            ratio_o = ratio_raw;
            enc_o   = enc_q;
            cmp_o   = cmp_q;
        end else begin
            ratio_o = 2'd0;
            enc_o   = 1'b0;
            cmp_o   = 1'b0;
        end
    end

endmodule

// File: rtl/hdr_ratio_detect_chk.sv
module hdr_ratio_detect_chk
    import hdr_ratio_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       s_ready_o,
    input logic       res_valid_o,
    input logic       err_o,
    input logic [1:0] ratio_o,
    input logic       enc_o,
    input logic       cmp_o,
    input logic       wide_q,
    input hdr_state_t state_q
);

    p_start_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_ready_o);

    p_x1_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !enc_o && !cmp_o) |-> (ratio_o == 2'd0));

    p_cmp_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && cmp_o) |-> (ratio_o == {1'b1, wide_q}));

    p_enc_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && enc_o && !cmp_o) |-> (ratio_o == (wide_q ? 2'd2 : 2'd1)));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_READY) && !start_i) |=> ($stable(ratio_o) && $stable(enc_o) && $stable(cmp_o)));

    p_err_no_ratio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ((ratio_o == 2'd0) && !enc_o && !cmp_o && !res_valid_o));

    p_err_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!s_ready_o || start_i));

endmodule

bind hdr_ratio_detect hdr_ratio_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .s_ready_o   (s_ready_o),
    .res_valid_o (res_valid_o),
    .err_o       (err_o),
    .ratio_o     (ratio_o),
    .enc_o       (enc_o),
    .cmp_o       (cmp_o),
    .wide_q      (wide_q),
    .state_q     (state_q)
);

// File: tb/hdr_ratio_detect_tb.sv
module hdr_ratio_detect_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cfg_wide_i = 1'b0;
    logic        s_valid_i = 1'b0;
    logic [31:0] s_data_i = '0;
    logic        s_last_i = 1'b0;
    logic        s_ready_o, res_valid_o, err_o, enc_o, cmp_o;
    logic [1:0]  ratio_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_P/2) clk = ~clk;

    hdr_ratio_detect dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_wide_i(cfg_wide_i),
        .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
        .s_ready_o(s_ready_o), .res_valid_o(res_valid_o), .err_o(err_o),
        .ratio_o(ratio_o), .enc_o(enc_o), .cmp_o(cmp_o)
    );

    // {wide, enc_field[1:0], cmp_bit, expected code[1:0]}
    localparam logic [5:0] VEC [8] = '{
        {1'b0, 2'b00, 1'b1, 2'd0},
        {1'b0, 2'b00, 1'b0, 2'd2},
        {1'b0, 2'b01, 1'b1, 2'd1},
        {1'b0, 2'b11, 1'b0, 2'd2},
        {1'b1, 2'b00, 1'b1, 2'd0},
        {1'b1, 2'b00, 1'b0, 2'd3},
        {1'b1, 2'b10, 1'b1, 2'd2},
        {1'b1, 2'b01, 1'b0, 2'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // filler words carry the opposite of the tested flags in the flag bits
    function automatic logic [31:0] word_for(input int idx, input logic [1:0] encf, input logic cmpb);
        logic [31:0] w;
        w = {idx[15:0], 16'h5A00};
        w[3:2] = (encf == 2'b00) ? 2'b11 : 2'b00;
        w[1]   = ~cmpb;
        if (idx == 69)  w[3:2] = encf;
        if (idx == 229) w[1]   = cmpb;
        return w;
    endfunction

    task automatic run_header(input logic wide, input logic [1:0] encf, input logic cmpb,
                              input int last_at, input int nwords, input bit gaps,
                              input bit start_beat);
        @(negedge clk);
        start_i    = 1'b1;
        cfg_wide_i = wide;
        if (start_beat) begin
            s_valid_i = 1'b1;
            s_data_i  = word_for(69, encf, cmpb);
        end
        #1;
        if (start_beat) chk("R2 ready low on start", {31'b0, s_ready_o}, 32'd0);
        @(negedge clk);
        start_i   = 1'b0;
        cfg_wide_i = ~wide;
        s_valid_i = 1'b0;
        for (int i = 0; i < nwords; i++) begin
            if (gaps && (i % 7 == 3)) begin
                s_valid_i = 1'b0;
                @(negedge clk);
            end
            s_valid_i = 1'b1;
            s_data_i  = word_for(i, encf, cmpb);
            s_last_i  = (i == last_at);
            @(negedge clk);
        end
        s_valid_i = 1'b0;
        s_last_i  = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready", {31'b0, s_ready_o}, 0);
        chk("R1 outputs", {26'b0, res_valid_o, err_o, ratio_o, enc_o, cmp_o}, 0);
        rst_n = 1'b1;

        // R10: beats offered in IDLE are ignored
        @(negedge clk);
        s_valid_i = 1'b1;
        s_last_i  = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk("R10 idle ignored", {29'b0, s_ready_o, res_valid_o, err_o}, 0);
        end
        s_valid_i = 1'b0;
        s_last_i  = 1'b0;

        // table of ratio cases, R3..R7
        for (int v = 0; v < 8; v++) begin
            logic [5:0] e;
            e = VEC[v];
            run_header(e[5], e[4:3], e[2], -1, 230, (v % 3 == 0), (v % 2 == 1));
            chk("R7 strobe", {31'b0, res_valid_o}, 1);
            chk("R5 R6 code", {30'b0, ratio_o}, {30'b0, e[1:0]});
            chk("R3 enc flag", {31'b0, enc_o}, {31'b0, (e[4:3] != 2'b00)});
            chk("R4 cmp flag", {31'b0, cmp_o}, {31'b0, ~e[2]});
            @(negedge clk);
            chk("R7 strobe one cycle", {31'b0, res_valid_o}, 0);
            chk("R7 code held", {30'b0, ratio_o}, {30'b0, e[1:0]});
        end

        // R7: payload after the header changes nothing
        run_header(1'b1, 2'b01, 1'b1, -1, 230, 0, 0);
        s_valid_i = 1'b1;
        for (int i = 0; i < 300; i++) begin
            s_data_i = word_for(i % 230, 2'b00, 1'b0) ^ 32'h0000_000E;
            @(negedge clk);
            if (i == 0 || i == 299) begin
                chk("R7 payload ignored", {27'b0, res_valid_o, ratio_o, enc_o, cmp_o},
                    {27'b0, 1'b0, 2'd2, 1'b1, 1'b0});
            end
        end
        s_valid_i = 1'b0;

        // R8: stream ends on word 100
        run_header(1'b0, 2'b11, 1'b0, 100, 101, 0, 0);
        chk("R8 error strobe", {31'b0, err_o}, 1);
        chk("R8 no result", {27'b0, res_valid_o, ratio_o, enc_o, cmp_o}, 0);
        chk("R8 ready low", {31'b0, s_ready_o}, 0);
        @(negedge clk);
        chk("R8 error one cycle", {31'b0, err_o}, 0);
        s_valid_i = 1'b1;
        repeat (140) @(negedge clk);
        chk("R10 abort ignores beats", {27'b0, res_valid_o, ratio_o, enc_o, cmp_o}, 0);
        s_valid_i = 1'b0;

        // R9: last marker on word 229 itself
        run_header(1'b1, 2'b00, 1'b0, 229, 230, 1, 0);
        chk("R9 result on last", {31'b0, res_valid_o}, 1);
        chk("R9 no error", {31'b0, err_o}, 0);
        chk("R9 code", {30'b0, ratio_o}, 3);

        // R2: restart in mid-header clears flags
        run_header(1'b0, 2'b01, 1'b0, -1, 120, 0, 0);
        run_header(1'b0, 2'b00, 1'b1, -1, 230, 0, 1);
        chk("R2 restart clears", {28'b0, res_valid_o, ratio_o, enc_o}, {28'b0, 1'b1, 2'd0, 1'b0});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule